// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block runs one request/reply exchange on a display auxiliary channel at the byte level. When `start` is pulsed, it captures a 4-bit command, a 20-bit address, a request length and an optional write payload. It then serialises the request bytes toward the line coder with a valid/ready handshake. After the last byte leaves, the block waits for the reply. It collects the returned bytes until the receiver reports completion, and it closes the exchange with a one-cycle `done` pulse carrying a result code, the reply status nibble and the received data bytes.

A programmable reply timer runs from microsecond ticks. A requested wait in microseconds is encoded into a 7-bit length scaled by one of four units. The timer starts when the last request byte is accepted and stops when the first reply byte arrives. The bit-level line coding and the analogue PHY sit outside this block. Receive-side error flags, the receiver's own timeout flag and a hot-plug disconnect level arrive as inputs.

Result codes on `result` are: 0 success, 1 timeout, 2 invalid reply, 3 disconnect.

Top module: `aux_xact_engine`

## Requirements
- R1: Request byte 0 is `{cmd, addr[19:16]}`, byte 1 is `addr[15:8]` and byte 2 is `addr[7:0]`. The bytes are presented on `tx_byte` in that order, one per accepted handshake.
- R2: When `req_len` is nonzero, a fourth byte equal to `req_len - 1` follows the address bytes. When `req_len` is zero, no such byte is sent.
- R3: A command with `cmd[0] == 0` is a write (native write 4'h8, I2C write 4'h0, I2C write with middle-of-transaction 4'h4); any other command is a read. `tx_count` equals 3 for zero length or 4 otherwise, plus `req_len` for writes only, and exactly that many bytes are sent.
- R4: For writes, payload byte k is taken from `wr_data[8k+7:8k]` and sent after the header in increasing k. Reads send no payload.
- R5: `reply_status` is the upper nibble of the first reply byte. On a reply with status 0 (ACK), `result` is success, `rd_count` is the reply byte count minus one, and data byte k lands in `rd_data[8k+7:8k]`. Any other status gives success with `rd_count` 0.
- R6: A reply that completes with zero received bytes gives invalid reply (2).
- R7: An ACK carrying more data bytes than `req_len` gives invalid reply (2), with `rd_count` 0.
- R8: While the block waits for or receives a reply, `hpd_discon` high ends the exchange with disconnect (3). This takes priority over every other outcome in the same cycle.
- R9: At completion, `rx_tmo_flag` gives timeout (1). Otherwise any bit of `rx_sym_err` gives invalid reply (2). The timeout flag outranks the symbol errors.
- R10: `tmo_len`/`tmo_mul` encode `timeout_us`. A value of 0 gives mul 0, len 69. Values up to 1016 give mul 0 and len ceil(t/8); up to 2032 give mul 1 and ceil(t/16); up to 4064 give mul 2 and ceil(t/32); above that give mul 3 and ceil(t/64). The length is clamped to 127.
- R11: The reply timer is loaded at `start` with `tmo_len << (3 + tmo_mul)` ticks. It counts `us_tick` only after the last request byte and before the first reply byte. The tick that reaches the limit ends the exchange with timeout (1), visible on the following cycle.
- R12: `done` is a one-cycle pulse, and `busy` is low whenever `done` is high. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a request (accepted when idle) |
| cmd | input | 4 | Command nibble |
| addr | input | 20 | Request address |
| req_len | input | $clog2(MAX_LEN+1) | Request length in bytes |
| wr_data | input | MAX_LEN*8 | Write payload, byte k at bits 8k+7:8k |
| timeout_us | input | 16 | Requested reply timeout in microseconds |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| tx_valid | output | 1 | Request byte available |
| tx_ready | input | 1 | Line coder accepts the byte |
| tx_byte | output | 8 | Current request byte |
| tx_count | output | $clog2(MAX_LEN+5) | Number of request bytes |
| rx_valid | input | 1 | Reply byte strobe |
| rx_byte | input | 8 | Reply byte |
| rx_done | input | 1 | Reply finished |
| rx_tmo_flag | input | 1 | Receiver timeout flag |
| rx_sym_err | input | 4 | Stop, no-detect, high and low symbol error flags |
| hpd_discon | input | 1 | Hot-plug disconnect level |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Exchange completed (one cycle) |
| result | output | 2 | 0 ok, 1 timeout, 2 invalid, 3 disconnect |
| reply_status | output | 4 | Upper nibble of first reply byte |
| rd_data | output | MAX_LEN*8 | Received data bytes |
| rd_count | output | $clog2(MAX_LEN+1) | Number of valid data bytes |
| tmo_len | output | 7 | Encoded timeout length |
| tmo_mul | output | 2 | Encoded timeout multiplier code |

## Verification
The bench builds the block with `MAX_LEN` set to 4. This keeps a full-length write of eight bytes and a reply that overruns the data storage within reach of short directed sequences. A timeout request of 3 µs gives a limit of 8 ticks, so the exact expiry tick can be checked and a stopped timer can be shown to stay silent well past it. Because the encoder is combinational, every range boundary of the timeout encoding is checked directly at its edge values.

// File: rtl/aux_xact_engine.sv
module aux_xact_engine #(
  parameter int MAX_LEN = 16,
  localparam int LW  = $clog2(MAX_LEN + 1),
  localparam int TCW = $clog2(MAX_LEN + 5),
  localparam int RXW = $clog2(MAX_LEN + 3)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [3:0]           cmd,
  input  logic [19:0]          addr,
  input  logic [LW-1:0]        req_len,
  input  logic [MAX_LEN*8-1:0] wr_data,
  input  logic [15:0]          timeout_us,
  input  logic                 us_tick,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_byte,
  output logic [TCW-1:0]       tx_count,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic                 rx_done,
  input  logic                 rx_tmo_flag,
  input  logic [3:0]           rx_sym_err,
  input  logic                 hpd_discon,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           result,
  output logic [3:0]           reply_status,
  output logic [MAX_LEN*8-1:0] rd_data,
  output logic [LW-1:0]        rd_count,
  output logic [6:0]           tmo_len,
  output logic [1:0]           tmo_mul
);

  localparam logic [1:0] RES_OK = 2'd0, RES_TMO = 2'd1, RES_INV = 2'd2, RES_DISC = 2'd3;
  localparam logic [RXW-1:0] RX_SAT = RXW'(MAX_LEN + 2);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RECV} state_t;
  state_t state;

  logic [3:0]           cmd_q;
  logic [19:0]          addr_q;
  logic [LW-1:0]        len_q;
  logic [MAX_LEN*8-1:0] wdata_q;
  logic [TCW-1:0]       idx;
  logic [12:0]          limit_q, tmr;
  logic [RXW-1:0]       rxn;
  logic [3:0]           status_q;

  // timeout encoder
  logic [16:0] t17, raw;
  assign t17 = {1'b0, timeout_us};
  always_comb begin
    if (timeout_us == 16'd0) begin
      tmo_mul = 2'd0; raw = 17'd69;
    end else if (timeout_us <= 16'd1016) begin
      tmo_mul = 2'd0; raw = (t17 + 17'd7) >> 3;
    end else if (timeout_us <= 16'd2032) begin
      tmo_mul = 2'd1; raw = (t17 + 17'd15) >> 4;
    end else if (timeout_us <= 16'd4064) begin
      tmo_mul = 2'd2; raw = (t17 + 17'd31) >> 5;
    end else begin
      tmo_mul = 2'd3; raw = (t17 + 17'd63) >> 6;
    end
    tmo_len = (raw > 17'd127) ? 7'd127 : raw[6:0];
  end

  logic [12:0]    limit_d;
  logic [TCW-1:0] cnt_d;
  assign limit_d = 13'(tmo_len) << (3'd3 + {1'b0, tmo_mul});
  assign cnt_d   = ((req_len != '0) ? TCW'(4) : TCW'(3)) + (cmd[0] ? TCW'(0) : TCW'(req_len));

  // transmit byte select
  logic [TCW-1:0]       pidx;
  logic [MAX_LEN*8-1:0] pay;
  always_comb begin
    pidx = idx - TCW'(4);
    pay  = wdata_q >> {pidx, 3'b000};
    if (idx == TCW'(0))      tx_byte = {cmd_q, addr_q[19:16]};
    else if (idx == TCW'(1)) tx_byte = addr_q[15:8];
    else if (idx == TCW'(2)) tx_byte = addr_q[7:0];
    else if (idx == TCW'(3)) tx_byte = 8'(len_q) - 8'd1;
    else                     tx_byte = pay[7:0];
  end

  assign tx_valid = (state == S_SEND);
  assign busy     = (state != S_IDLE);

  // completion decision
  logic       listening, fin;
  logic [1:0] fres;
  assign listening = (state == S_WAIT) || (state == S_RECV);
  always_comb begin
    fin  = 1'b0;
    fres = RES_OK;
    if (listening) begin
      if (hpd_discon) begin
        fin = 1'b1; fres = RES_DISC;
      end else if (rx_done) begin
        fin = 1'b1;
        if (rx_tmo_flag)                 fres = RES_TMO;
        else if (|rx_sym_err)            fres = RES_INV;
        else if (rxn == '0)              fres = RES_INV;
        else if (status_q == 4'd0 && (rxn - RXW'(1)) > RXW'(len_q)) fres = RES_INV;
      end else if (state == S_WAIT && us_tick && tmr == limit_q - 13'd1) begin
        fin = 1'b1; fres = RES_TMO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cmd_q        <= '0;
      addr_q       <= '0;
      len_q        <= '0;
      wdata_q      <= '0;
      idx          <= '0;
      tx_count     <= '0;
      limit_q      <= '0;
      tmr          <= '0;
      rxn          <= '0;
      status_q     <= '0;
      rd_data      <= '0;
      rd_count     <= '0;
      reply_status <= '0;
      result       <= RES_OK;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_SEND;
          cmd_q    <= cmd;
          addr_q   <= addr;
          len_q    <= req_len;
          wdata_q  <= wr_data;
          tx_count <= cnt_d;
          limit_q  <= limit_d;
          idx      <= '0;
          rxn      <= '0;
          status_q <= '0;
          rd_data  <= '0;
        end
        S_SEND: if (tx_ready) begin
          idx <= idx + TCW'(1);
          if (idx == tx_count - TCW'(1)) begin
            state <= S_WAIT;
            tmr   <= '0;
          end
        end
        default: begin
          if (fin) begin
            state        <= S_IDLE;
            done         <= 1'b1;
            result       <= fres;
            reply_status <= status_q;
            rd_count     <= (fres == RES_OK && status_q == 4'd0) ? LW'(rxn - RXW'(1)) : '0;
          end else begin
            if (state == S_WAIT && us_tick) tmr <= tmr + 13'd1;
            if (rx_valid) begin
              state <= S_RECV;
              if (rxn != RX_SAT) rxn <= rxn + RXW'(1);
              if (rxn == '0) status_q <= rx_byte[7:4];
              for (int k = 0; k < MAX_LEN; k++)
                if (rxn == RXW'(k + 1)) rd_data[k*8 +: 8] <= rx_byte;
            end
          end
        end
      endcase
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_needs_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_OK) |-> rd_count <= len_q);
  assert_fail_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != RES_OK) |-> rd_count == '0);
  assert_len_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_len != 7'd0);
  assert_quiet_listen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (listening && !fin) |=> !tx_valid);

endmodule

// File: tb/test_aux_xact_engine.sv
module test_aux_xact_engine;
  localparam int ML = 4;
  localparam int LW = $clog2(ML + 1);
  localparam int TCW = $clog2(ML + 5);

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [3:0] cmd = 0;
  logic [19:0] addr = 0;
  logic [LW-1:0] req_len = 0;
  logic [ML*8-1:0] wr_data = 0;
  logic [15:0] timeout_us = 0;
  logic us_tick = 0, tx_ready = 1;
  logic tx_valid;
  logic [7:0] tx_byte;
  logic [TCW-1:0] tx_count;
  logic rx_valid = 0, rx_done = 0, rx_tmo_flag = 0, hpd_discon = 0;
  logic [7:0] rx_byte = 0;
  logic [3:0] rx_sym_err = 0;
  logic busy, done;
  logic [1:0] result;
  logic [3:0] reply_status;
  logic [ML*8-1:0] rd_data;
  logic [LW-1:0] rd_count;
  logic [6:0] tmo_len;
  logic [1:0] tmo_mul;

  aux_xact_engine #(.MAX_LEN(ML)) i_aux_xact_engine (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] expb [0:15];
  int expn;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  task automatic build_exp(logic [3:0] c, logic [19:0] a, int len, logic [ML*8-1:0] d);
    expb[0] = {c, a[19:16]};
    expb[1] = a[15:8];
    expb[2] = a[7:0];
    expn = 3;
    if (len != 0) begin expb[3] = 8'(len - 1); expn = 4; end
    if (c[0] == 1'b0)
      for (int k = 0; k < len; k++) begin expb[expn] = d[k*8 +: 8]; expn++; end
  endtask

  // start a request and check the transmitted bytes (R1-R4)
  task automatic send_req(logic [3:0] c, logic [19:0] a, int len, logic [ML*8-1:0] d, logic [15:0] t);
    int got;
    build_exp(c, a, len, d);
    cmd = c; addr = a; req_len = LW'(len); wr_data = d; timeout_us = t;
    start = 1; @(negedge clk); start = 0;
    check("R3 tx_count", int'(tx_count), expn);
    got = 0;
    for (int i = 0; i < 40 && tx_valid; i++) begin
      if (got < 16) begin
        if (got < 3)      check("R1 header byte", tx_byte, expb[got]);
        else if (got == 3 && len != 0) check("R2 length byte", tx_byte, expb[got]);
        else              check("R4 payload byte", tx_byte, expb[got]);
      end
      got++;
      @(negedge clk);
    end
    check("R3 bytes sent", got, expn);
  endtask

  task automatic rx_put(logic [7:0] b);
    rx_valid = 1; rx_byte = b; @(negedge clk); rx_valid = 0;
  endtask

  task automatic rx_end();
    rx_done = 1; @(negedge clk); rx_done = 0;
  endtask

  task automatic expect_done(string req, int res);
    check({req, " done"}, done, 1);
    check({req, " result"}, result, res);
    @(negedge clk);
    check("R12 done pulse", done, 0);
  endtask

  task automatic t_reset();
    check("R12 reset busy", busy, 0);
    check("R12 reset done", done, 0);
    check("R12 reset tx_valid", tx_valid, 0);
  endtask

  task automatic t_read_ack();
    send_req(4'h9, 20'h5A3C1, 3, '0, 16'd400);
    rx_put(8'h00); rx_put(8'hDE); rx_put(8'hAD); rx_put(8'hBE);
    rx_end();
    check("R5 status", reply_status, 0);
    check("R5 rd_count", rd_count, 3);
    check("R5 rd_data", int'(rd_data[23:0]), 24'hBEADDE);
    expect_done("R5 ack", 0);
  endtask

  task automatic t_writes();
    send_req(4'h8, 20'h00102, 2, 32'h0000_2211, 16'd400);
    rx_put(8'h00); rx_end();
    check("R5 write ack count", rd_count, 0);
    expect_done("R5 write ack", 0);
    send_req(4'h4, 20'hABCDE, 4, 32'h4433_2211, 16'd400);
    rx_put(8'h00); rx_end();
    expect_done("R3 i2c mot write", 0);
    send_req(4'h0, 20'h00050, 0, 32'hFFFF_FFFF, 16'd400);
    rx_put(8'h00); rx_end();
    expect_done("R2 zero-length write", 0);
    send_req(4'h1, 20'hF0050, 0, '0, 16'd400);
    rx_put(8'h00); rx_end();
    expect_done("R2 zero-length read", 0);
    send_req(4'h5, 20'h12345, 4, 32'hDEAD_BEEF, 16'd400);
    rx_put(8'h00); rx_put(8'h77); rx_end();
    check("R5 short ack count", rd_count, 1);
    check("R5 short ack data", rd_data[7:0], 8'h77);
    expect_done("R5 short ack", 0);
  endtask

  task automatic t_nack();
    send_req(4'h9, 20'h00200, 2, '0, 16'd400);
    rx_put(8'h10); rx_end();
    check("R5 nack status", reply_status, 1);
    check("R5 nack count", rd_count, 0);
    expect_done("R5 nack", 0);
  endtask

  task automatic t_empty();
    send_req(4'h9, 20'h00300, 1, '0, 16'd400);
    rx_end();
    expect_done("R6 empty reply", 2);
  endtask

  task automatic t_overflow();
    send_req(4'h9, 20'h00400, 2, '0, 16'd400);
    rx_put(8'h00); rx_put(8'h01); rx_put(8'h02); rx_put(8'h03);
    rx_end();
    check("R7 overflow count", rd_count, 0);
    expect_done("R7 overflow", 2);
    send_req(4'h9, 20'h00400, 4, '0, 16'd400);
    for (int i = 0; i < 7; i++) rx_put(8'h00);
    rx_end();
    expect_done("R7 long overflow", 2);
  endtask

  task automatic t_hpd();
    send_req(4'h9, 20'h00500, 1, '0, 16'd400);
    hpd_discon = 1; @(negedge clk); hpd_discon = 0;
    expect_done("R8 hpd waiting", 3);
    send_req(4'h9, 20'h00500, 1, '0, 16'd400);
    rx_put(8'h00);
    hpd_discon = 1; rx_done = 1; rx_tmo_flag = 1; @(negedge clk);
    hpd_discon = 0; rx_done = 0; rx_tmo_flag = 0;
    expect_done("R8 hpd priority", 3);
  endtask

  task automatic t_flags();
    send_req(4'h9, 20'h00600, 1, '0, 16'd400);
    rx_put(8'h00); rx_put(8'h01);
    rx_tmo_flag = 1; rx_sym_err = 4'hF; rx_end(); rx_tmo_flag = 0; rx_sym_err = 0;
    expect_done("R9 tmo flag priority", 1);
    for (int b = 0; b < 4; b++) begin
      send_req(4'h9, 20'h00600, 1, '0, 16'd400);
      rx_put(8'h00); rx_put(8'h01);
      rx_sym_err = 4'(1 << b); rx_end(); rx_sym_err = 0;
      expect_done("R9 symbol error", 2);
    end
  endtask

  task automatic t_expiry();
    send_req(4'h9, 20'h00700, 1, '0, 16'd3);
    for (int i = 0; i < 7; i++) begin
      us_tick = 1; @(negedge clk); us_tick = 0; @(negedge clk);
    end
    check("R11 not expired at 7 ticks", done, 0);
    check("R11 still busy", busy, 1);
    us_tick = 1; @(negedge clk); us_tick = 0;
    expect_done("R11 expiry at 8 ticks", 1);
  endtask

  task automatic t_timer_stops();
    int seen = 0;
    send_req(4'h9, 20'h00800, 0, '0, 16'd3);
    rx_put(8'h00);
    for (int i = 0; i < 20; i++) begin
      us_tick = 1; @(negedge clk); us_tick = 0;
      if (done) seen = 1;
      @(negedge clk);
    end
    check("R11 timer stopped by reply", seen, 0);
    rx_end();
    expect_done("R11 reply after ticks", 0);
  endtask

  task automatic t_busy_ignore();
    send_req(4'h9, 20'h00900, 1, '0, 16'd400);
    cmd = 4'h8; start = 1; @(negedge clk); start = 0;
    check("R12 start ignored tx_valid", tx_valid, 0);
    check("R12 start ignored busy", busy, 1);
    rx_put(8'h20); rx_end();
    check("R12 status after ignored start", reply_status, 2);
    expect_done("R12 ignored start", 0);
  endtask

  task automatic enc(int t, int m, int l);
    timeout_us = 16'(t); #1;
    check("R10 tmo_mul", tmo_mul, m);
    check("R10 tmo_len", tmo_len, l);
  endtask

  task automatic t_encode();
    enc(0, 0, 69); enc(1, 0, 1); enc(8, 0, 1); enc(9, 0, 2);
    enc(1016, 0, 127); enc(1017, 1, 64); enc(2032, 1, 127);
    enc(2033, 2, 64); enc(4064, 2, 127); enc(4065, 3, 64);
    enc(8128, 3, 127); enc(8129, 3, 127); enc(65535, 3, 127);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_read_ack();
    t_writes();
    t_nack();
    t_empty();
    t_overflow();
    t_hpd();
    t_flags();
    t_expiry();
    t_timer_stops();
    t_busy_ignore();
    t_encode();
    report();
  end
endmodule